// File: doc/BRIEF.md
# Predicated Control Sequencer

This block is a small microcoded engine that takes the place of a hard-wired control state machine. While the engine is halted, a host loads a short program through a plain address/data/write-enable port. A start pulse then sets the engine running. Every cycle it issues the next instruction in straight-line order. After the host-chosen last address it wraps back to address 0, so the program repeats until the host stops it. The instructions set and clear bits of a control output register, and they compare the status inputs against a pattern to update three internal flags.

The program has no way to jump. Conditional behaviour comes only from a predicate that every instruction carries. When the predicate is false the instruction is dropped and changes nothing. Instructions move through three stages: fetch, decode and execute. The predicate is resolved in the decode stage. Nothing stalls or forwards, so a flag written by one instruction is only seen by the instruction two places after it. The program must be scheduled around this delay.

Top module: `mseq_top`

## Requirements
- R1: After a synchronous reset, `ctl_out` is 0 and `busy` is 0. Reset does not alter the instruction memory.
- R2: A load-port write stores `ld_data` at `ld_addr` only while `busy` is 0 and `ld_addr` is below 24. A write attempted while running leaves the memory unchanged.
- R3: A `start` pulse sets `busy`, clears the program counter and all three flags, and drops every instruction in flight. The effect of the instruction at address 0 appears on `ctl_out` three clock edges after the edge that samples `start`.
- R4: One instruction issues per cycle, in address order. After the instruction at `prog_last`, issue wraps to address 0. A `prog_last` of 23 or above acts as 23.
- R5: The instruction word is 16 bits: [15:13] opcode (0 NOP, 1 SET, 2 CLR, 3 CMP, 4 to 7 behave as NOP), [12:11] predicate select, [10] predicate invert, [9:0] argument.
- R6: SET ORs the argument into `ctl_out`. CLR clears in `ctl_out` the bits that are set in the argument.
- R7: CMP writes flag n, where n is argument[9:8] and n = 0 writes no flag. The flag becomes 1 when (`status` AND argument[7:4]) equals (argument[3:0] AND argument[7:4]), and 0 otherwise.
- R8: The predicate value is 1 for select 0, or flag n for select n = 1 to 3. The invert bit XORs this value. An instruction whose predicate value is 0 changes neither `ctl_out` nor any flag.
- R9: The instruction right after a CMP evaluates its predicate on the flag values from before that CMP. The second instruction after it sees the new value.
- R10: A `stop` pulse clears `busy` on the next edge. The instruction in execute on that edge still completes, and nothing issues after it.
- R11: While `busy` is 0, `ctl_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Restart program at address 0 |
| stop | input | 1 | Halt the engine |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 5 | Load-port word address |
| ld_data | input | 16 | Load-port instruction word |
| prog_last | input | 5 | Address of the last program instruction |
| status | input | 4 | Status lines tested by CMP |
| ctl_out | output | 10 | Control output register |
| busy | output | 1 | Engine running |

## Verification
The instruction fetched at address k after a start shows its result on `ctl_out` at edge 3+k, counting the start edge as 0. A stop shows on `busy` one edge after it is sampled. The bench drives inputs on falling edges. A behavioural reference model advances on each rising edge, and every falling edge compares `ctl_out` and `busy` with the model. Directed checks count falling edges from the start edge to land on the exact slot of each instruction. This matters most for the flag-delay case, where the instruction one slot after a CMP must still read the old flag and the one two slots after must read the new one.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int IW     = 16;
    localparam int ARG_W  = 10;
    localparam int OUT_W  = ARG_W;
    localparam int STAT_W = 4;
    localparam int NFLAG  = 3;

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_SET = 3'd1;
    localparam logic [2:0] OP_CLR = 3'd2;
    localparam logic [2:0] OP_CMP = 3'd3;

    typedef struct packed {
        logic [2:0]       op;
        logic [1:0]       psel;
        logic             pinv;
        logic [ARG_W-1:0] arg;
    } instr_t;

    typedef struct packed {
        logic              valid;
        logic              do_set;
        logic              do_clr;
        logic              do_cmp;
        logic [1:0]        fidx;
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] pat;
        logic [OUT_W-1:0]  bits;
    } uop_t;

    function automatic logic pred_eval(input logic [NFLAG:1] f,
                                       input logic [1:0] sel,
                                       input logic inv);
        logic r;
        case (sel)
            2'd1:    r = f[1];
            2'd2:    r = f[2];
            2'd3:    r = f[3];
            default: r = 1'b1;
        endcase
        return r ^ inv;
    endfunction
endpackage

// File: rtl/mseq_imem.sv
module mseq_imem
    import mseq_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  instr_t        wdata,
    input  logic [AW-1:0] raddr,
    output instr_t        rdata
);
    instr_t mem [DEPTH];
    logic   wr_ok;

    assign wr_ok = we && !busy && (waddr < AW'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_ok) mem[waddr] <= wdata;
    end

    assign rdata = (raddr < AW'(DEPTH)) ? mem[raddr] : '0;

    // R2
    ign_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && we && (waddr < AW'(DEPTH))) |=> (mem[$past(waddr)] == $past(mem[waddr])));
endmodule

// File: rtl/mseq_fetch.sv
module mseq_fetch
    import mseq_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          start,
    input  logic          stop,
    input  logic [AW-1:0] last,
    input  instr_t        rdata,
    output logic [AW-1:0] pc,
    output logic          if_valid,
    output instr_t        if_instr
);
    logic [AW-1:0] lim;

    assign lim = (last > AW'(DEPTH - 1)) ? AW'(DEPTH - 1) : last;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            if_valid <= 1'b0;
            if_instr <= '0;
        end else if (start) begin
            pc       <= '0;
            if_valid <= 1'b0;
        end else if (run) begin
            if_valid <= !stop;
            if_instr <= rdata;
            pc       <= (pc >= lim) ? '0 : pc + AW'(1);
        end else begin
            if_valid <= 1'b0;
        end
    end

    // R3
    start_pc_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (pc == '0) && !if_valid);

    // R4
    pc_range_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !start) |=> (pc <= lim));

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !start && pc < lim) |=> (pc == $past(pc) + AW'(1)));
endmodule

// File: rtl/mseq_decode.sv
module mseq_decode
    import mseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic           start,
    input  logic           stop,
    input  logic           if_valid,
    input  instr_t         if_instr,
    input  logic [NFLAG:1] flags,
    output uop_t           uop,
    output logic           pred
);
    uop_t dec;

    always_comb begin
        dec        = '0;
        dec.valid  = if_valid && run && !start && !stop;
        dec.do_set = (if_instr.op == OP_SET);
        dec.do_clr = (if_instr.op == OP_CLR);
        dec.do_cmp = (if_instr.op == OP_CMP);
        dec.fidx   = if_instr.arg[9:8];
        dec.mask   = if_instr.arg[7:4];
        dec.pat    = if_instr.arg[3:0];
        dec.bits   = if_instr.arg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uop  <= '0;
            pred <= 1'b0;
        end else begin
            uop  <= dec;
            pred <= pred_eval(flags, if_instr.psel, if_instr.pinv);
        end
    end

    // R3
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !uop.valid);
endmodule

// File: rtl/mseq_exec.sv
module mseq_exec
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              start,
    input  uop_t              uop,
    input  logic              pred,
    input  logic [STAT_W-1:0] status,
    output logic [OUT_W-1:0]  ctl,
    output logic [NFLAG:1]    flags
);
    logic           fire;
    logic           match;
    logic [NFLAG:1] flags_n;
    logic [OUT_W-1:0] ctl_n;

    assign fire  = run && uop.valid && pred && !start;
    assign match = ((status & uop.mask) == (uop.pat & uop.mask));

    always_comb begin
        flags_n = flags;
        ctl_n   = ctl;
        if (fire && uop.do_cmp) begin
            case (uop.fidx)
                2'd1:    flags_n[1] = match;
                2'd2:    flags_n[2] = match;
                2'd3:    flags_n[3] = match;
                default: ;
            endcase
        end
        if (fire && uop.do_set) ctl_n = ctl | uop.bits;
        if (fire && uop.do_clr) ctl_n = ctl & ~uop.bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= '0;
            flags <= '0;
        end else begin
            ctl   <= ctl_n;
            flags <= start ? '0 : flags_n;
        end
    end

    // R8
    squash_chk: assert property (@(posedge clk) disable iff (rst)
        (uop.valid && !pred && !start) |=> $stable(ctl) && $stable(flags));

    // R3
    start_flag_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (flags == '0));

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(ctl));
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int DEPTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              ld_we,
    input  logic [AW-1:0]     ld_addr,
    input  logic [IW-1:0]     ld_data,
    input  logic [AW-1:0]     prog_last,
    input  logic [STAT_W-1:0] status,
    output logic [OUT_W-1:0]  ctl_out,
    output logic              busy
);
    logic [AW-1:0]  pc;
    instr_t         rdata;
    logic           if_valid;
    instr_t         if_instr;
    uop_t           uop;
    logic           pred;
    logic [NFLAG:1] flags;

    always_ff @(posedge clk) begin
        if (rst)        busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (stop)  busy <= 1'b0;
    end

    mseq_imem #(.DEPTH(DEPTH)) u_imem (
        .clk(clk), .rst(rst), .busy(busy), .we(ld_we), .waddr(ld_addr),
        .wdata(instr_t'(ld_data)), .raddr(pc), .rdata(rdata)
    );

    mseq_fetch #(.DEPTH(DEPTH)) u_fetch (
        .clk(clk), .rst(rst), .run(busy), .start(start), .stop(stop),
        .last(prog_last), .rdata(rdata), .pc(pc), .if_valid(if_valid),
        .if_instr(if_instr)
    );

    mseq_decode u_decode (
        .clk(clk), .rst(rst), .run(busy), .start(start), .stop(stop),
        .if_valid(if_valid), .if_instr(if_instr), .flags(flags),
        .uop(uop), .pred(pred)
    );

    mseq_exec u_exec (
        .clk(clk), .rst(rst), .run(busy), .start(start), .uop(uop),
        .pred(pred), .status(status), .ctl(ctl_out), .flags(flags)
    );

    // R10
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> !busy);

    // R1
    reset_chk: assert property (@(posedge clk)
        rst |=> (ctl_out == '0) && !busy);
endmodule

// File: tb/test_mseq_top.sv
module test_mseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        ld_we = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [4:0]  prog_last = '0;
    logic [3:0]  status = '0;
    logic [9:0]  ctl_out;
    logic        busy;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mseq_top i_mseq_top (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .ld_we(ld_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .prog_last(prog_last),
        .status(status), .ctl_out(ctl_out), .busy(busy)
    );

    // Behavioural reference model
    logic [15:0] m_mem [DEPTH];
    logic [9:0]  m_out = '0;
    logic        m_run = 1'b0;
    int          m_pc = 0;
    logic        m_ifv = 1'b0;
    logic [15:0] m_if = '0;
    logic        m_exv = 1'b0;
    logic [15:0] m_ex = '0;
    logic        m_expred = 1'b0;
    logic [3:1]  m_flags = '0;

    function automatic logic m_pred(logic [3:1] f, logic [15:0] w);
        logic v;
        v = (w[12:11] == 2'd0) ? 1'b1 : f[w[12:11]];
        return v ^ w[10];
    endfunction

    always @(posedge clk) begin
        logic [3:1] nf;
        logic [9:0] a;
        int lim;
        if (rst) begin
            m_out = '0; m_run = 0; m_pc = 0; m_ifv = 0; m_exv = 0; m_flags = '0;
        end else begin
            nf = m_flags;
            a  = m_ex[9:0];
            if (m_run && m_exv && m_expred && !start) begin
                if (m_ex[15:13] == 3'd1) m_out = m_out | a;
                else if (m_ex[15:13] == 3'd2) m_out = m_out & ~a;
                else if (m_ex[15:13] == 3'd3 && a[9:8] != 2'd0)
                    nf[a[9:8]] = ((status & a[7:4]) == (a[3:0] & a[7:4]));
            end
            m_exv    = m_ifv && m_run && !start && !stop;
            m_ex     = m_if;
            m_expred = m_pred(m_flags, m_if);
            lim = (int'(prog_last) > DEPTH-1) ? DEPTH-1 : int'(prog_last);
            if (start) begin
                m_pc = 0; m_ifv = 0;
            end else if (m_run) begin
                m_ifv = !stop;
                m_if  = m_mem[m_pc];
                m_pc  = (m_pc >= lim) ? 0 : m_pc + 1;
            end else begin
                m_ifv = 0;
            end
            if (ld_we && !m_run && int'(ld_addr) < DEPTH) m_mem[ld_addr] = ld_data;
            m_flags = start ? 3'b000 : nf;
            if (start) m_run = 1;
            else if (stop) m_run = 0;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(tag, {6'd0, ctl_out}, {6'd0, m_out});
            chk(tag, {15'd0, busy}, {15'd0, m_run});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(int a, logic [15:0] d);
        ld_we = 1'b1; ld_addr = 5'(a); ld_data = d;
        tick(1);
        ld_we = 1'b0;
    endtask

    task automatic go();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    task automatic halt_eng();
        stop = 1'b1; tick(1); stop = 1'b0;
    endtask

    task automatic reset_pulse();
        rst = 1'b1; tick(1); rst = 1'b0;
    endtask

    initial begin
        logic [9:0] held;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        tick(2);
        rst = 1'b0;
        cmp_en = 1'b1;
        // R1 reset state
        chk("R1", {6'd0, ctl_out}, 16'h0000);
        chk("R1", {15'd0, busy}, 16'h0000);

        // Program A: SET 3FF, CLR 00F, NOP, loop at 2 (R5, R6)
        tag = "R5";
        for (int i = 0; i < DEPTH; i++) load(i, 16'h0000);
        load(0, 16'h23FF);
        load(1, 16'h400F);
        prog_last = 5'd2;
        tag = "R6";
        go();
        tick(3);
        chk("R3", {6'd0, ctl_out}, 16'h03FF);
        tick(1);
        chk("R6", {6'd0, ctl_out}, 16'h03F0);
        tick(2);
        chk("R4", {6'd0, ctl_out}, 16'h03FF);

        // Write while running must be ignored (R2)
        tag = "R2";
        load(0, 16'h0000);
        tick(5);
        tag = "R10";
        halt_eng();
        chk("R10", {15'd0, busy}, 16'h0000);
        held = ctl_out;
        tag = "R11";
        tick(6);
        chk("R11", {6'd0, ctl_out}, {6'd0, held});
        reset_pulse();
        tag = "R2";
        go();
        tick(3);
        chk("R2", {6'd0, ctl_out}, 16'h03FF);
        halt_eng();

        // Program B: predicates and flag delay (R7, R8, R9)
        reset_pulse();
        tag = "R9";
        load(0, 16'h61F5);  // CMP flag1, mask F, pattern 5
        load(1, 16'h2810);  // SET 010 if flag1
        load(2, 16'h2820);  // SET 020 if flag1
        load(3, 16'h2C40);  // SET 040 if !flag1
        load(4, 16'h2480);  // SET 080 never
        prog_last = 5'd4;
        status = 4'b0101;
        go();
        tick(4);
        chk("R9", {6'd0, ctl_out}, 16'h0000);
        tick(1);
        chk("R9", {6'd0, ctl_out}, 16'h0020);
        tick(4);
        chk("R9", {6'd0, ctl_out}, 16'h0030);
        tag = "R8";
        tick(10);
        chk("R8", {6'd0, ctl_out}, 16'h0030);

        // Mismatch clears flag1: only the inverted SET runs (R7)
        halt_eng();
        reset_pulse();
        tag = "R7";
        status = 4'b0100;
        go();
        tick(12);
        chk("R7", {6'd0, ctl_out}, 16'h0040);

        // Restart while running clears flags and flushes (R3)
        tag = "R3";
        status = 4'b0101;
        tick(7);
        go();
        tick(12);
        chk("R3", {6'd0, ctl_out}, 16'h0070);
        halt_eng();

        // Over-range program length acts as 23 (R4)
        reset_pulse();
        tag = "R4";
        for (int i = 0; i < DEPTH; i++) load(i, 16'h0000);
        load(0, 16'h2001);
        load(23, 16'h4001);
        prog_last = 5'd31;
        go();
        tick(3);
        chk("R4", {6'd0, ctl_out}, 16'h0001);
        tick(23);
        chk("R4", {6'd0, ctl_out}, 16'h0000);
        tick(1);
        chk("R4", {6'd0, ctl_out}, 16'h0001);
        halt_eng();
        tick(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule